// File: doc/BRIEF.md
# JTAG Scan Command Engine

This block is a single-device JTAG master. A host issues one command and the block produces the complete TCK/TMS/TDI waveform for it, reads TDO, and reports completion. There are three commands. The first forces the target TAP into Run-Test-Idle from any state. The second loads an instruction register of up to `IR_MAX` bits. The third exchanges a data register of up to `DR_MAX` bits. Every scan command starts in Run-Test-Idle and finishes there.

Each TCK pulse is built from three equal half-periods:
1. TMS and TDI are set up while TCK is low.
2. TCK is raised.
3. TCK is lowered, and TDO is read at the end of this third half-period.

The half-period is a count of system clocks, taken from `half_div` when a command is accepted. This lets software keep TCK at or below one eighth of the target's own clock.

A separate request pulls the target's reset line low through an open-drain enable. The line is never driven high.

Top module: `jtag_scan_engine`

## Requirements
- R1: After reset, the block holds the following outputs: `tck`=0, `tms`=1, `tdi`=1, `busy`=0, `done`=0, `trst_oe`=0 and `dout`=0.
- R2: Each TCK pulse lasts three half-periods of `half_div` system clocks each. A `half_div` of 0 counts as 1. `busy` stays high for exactly 3 × pulses × half-period clocks. TMS and TDI never change while TCK is high.
- R3: Command code 0 (and the spare code 3) gives 8 TCK pulses. TMS is 1 on the first seven and 0 on the last, which leaves the TAP in Run-Test-Idle.
- R4: Command code 1 gives an instruction scan of n+6 pulses, with TMS in this order:
  - 1,1,0,0 as the preamble;
  - 0 on each data bit except the last, which has 1;
  - then 1, then 0.
  n is `len`, where 0 counts as 1 and values above `IR_MAX` count as `IR_MAX`.
- R5: Command code 2 gives a data scan of n+5 pulses, with TMS in this order:
  - 1,0,0 as the preamble;
  - the data bits, as in R4;
  - then 1, then 0.
  n is clamped to 1..`DR_MAX`.
- R6: Bit i of `din` is on TDI at the rising edge of data pulse i (LSB first). `din` bits at positions n and above are never shifted out.
- R7: Bit i of `dout` holds the TDO level read after the falling TCK edge just before data pulse i. Bits at positions n and above are 0. `dout` holds its value from `done` until the next accepted start.
- R8: `done` is a one-cycle pulse, asserted in the cycle that `busy` falls.
- R9: A `start` while `busy` is high is ignored. The running command's pulses, TMS pattern and result are unchanged.
- R10: `trst_oe` follows `trst_req` one clock later, whether or not a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when not busy |
| cmd | input | 2 | 0 idle-reset, 1 instruction scan, 2 data scan, 3 as 0 |
| len | input | LEN_W | Scan length in bits |
| din | input | DR_MAX | Bits to shift out, LSB first |
| half_div | input | DIV_W | TCK half-period in system clocks |
| trst_req | input | 1 | Request to pull the target reset low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | DR_MAX | Captured TDO bits, LSB first |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |
| trst_oe | output | 1 | Open-drain low-drive enable for target reset |

## Verification
The bench sweeps every scan length from 0 to one past each maximum, for both scan types and for three half-period settings (0, 1 and 2). Length 0 and the over-length cases separate correct clamping from wraparound. The settings 0 and 1 show that a zero divider is treated as 1, and setting 2 exposes any miscount in the phase timing. A behavioural TAP model follows TMS through all sixteen states. It captures a known pattern and shifts a per-length data word, so that it can detect each of these faults:
- a wrong preamble;
- a missing exit or update step;
- a bit order reversed;
- TDO read off by one pulse.
Starts issued mid-command and toggled reset requests cover the remaining control paths.

// File: rtl/jscan_pkg.sv
package jscan_pkg;
  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_IR    = 2'd1,
    CMD_DR    = 2'd2,
    CMD_SPARE = 2'd3
  } scan_cmd_e;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_HIGH  = 2'd1,
    PH_LOW   = 2'd2
  } tck_phase_e;
endpackage

// File: rtl/jscan_halfper.sv
module jscan_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff;

  assign eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      div_q <= eff;
      cnt_q <= eff - DIV_W'(1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= div_q - DIV_W'(1);
      else             cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R2: the half-period counter never reaches the latched divider
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < div_q));
  // R2: a zero divider is never latched
  a_r2_div_nonzero: assert property (@(posedge clk) disable iff (rst)
    div_q != '0);
endmodule

// File: rtl/jscan_stepgen.sv
module jscan_stepgen
  import jscan_pkg::*;
#(
  parameter int DR_MAX = 16,
  parameter int LEN_W  = $clog2(DR_MAX + 1),
  parameter int STEP_W = $clog2(DR_MAX + 7),
  parameter int IDX_W  = (DR_MAX > 1) ? $clog2(DR_MAX) : 1
) (
  input  scan_cmd_e         cmd,
  input  logic [LEN_W-1:0]  n,
  input  logic [STEP_W-1:0] step,
  output logic              tms,
  output logic              is_data,
  output logic              is_last,
  output logic              capture,
  output logic [IDX_W-1:0]  data_idx,
  output logic [IDX_W-1:0]  cap_idx
);
  localparam int SW = STEP_W + 1;

  logic [SW-1:0] s, nn, pre, s1;

  always_comb begin
    s   = SW'(step);
    s1  = s + SW'(1);
    nn  = SW'(n);
    pre = (cmd == CMD_IR) ? SW'(4) : SW'(3);
    data_idx = IDX_W'(s - pre);
    cap_idx  = IDX_W'(s1 - pre);
    if (cmd == CMD_RESET) begin
      tms     = (s < SW'(7));
      is_last = (s == SW'(7));
      is_data = 1'b0;
      capture = 1'b0;
    end else begin
      is_last = (s == pre + nn + SW'(1));
      is_data = (s >= pre) && (s < pre + nn);
      capture = (s1 >= pre) && (s1 < pre + nn);
      if (s < pre)
        tms = (cmd == CMD_IR) ? (s < SW'(2)) : (s == '0);
      else if (is_data)
        tms = (s == pre + nn - SW'(1));
      else
        tms = (s == pre + nn);
    end
  end
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
  import jscan_pkg::*;
#(
  parameter int IR_MAX = 8,
  parameter int DR_MAX = 16,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = $clog2(DR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cmd,
  input  logic [LEN_W-1:0]  len,
  input  logic [DR_MAX-1:0] din,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              trst_req,
  output logic              busy,
  output logic              done,
  output logic [DR_MAX-1:0] dout,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  input  logic              tdo,
  output logic              trst_oe
);
  localparam int STEP_W = $clog2(DR_MAX + 7);
  localparam int IDX_W  = (DR_MAX > 1) ? $clog2(DR_MAX) : 1;

  scan_cmd_e         cmd_q, cmd_in;
  tck_phase_e        phase_q;
  logic [LEN_W-1:0]  len_q, len_eff, lim;
  logic [DR_MAX-1:0] din_q, cap_q;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              busy_q, done_q, tck_q, tms_q, tdi_q, trst_q;
  logic              tick, accept;

  logic              c_tms, c_data, c_last, c_cap;
  logic [IDX_W-1:0]  c_didx, c_cidx;
  logic              n_tms, n_data, n_last, n_cap;
  logic [IDX_W-1:0]  n_didx, n_cidx;

  assign accept  = start && !busy_q;
  assign cmd_in  = (cmd == 2'd3) ? CMD_RESET : scan_cmd_e'(cmd);
  assign lim     = (cmd_in == CMD_IR) ? LEN_W'(IR_MAX) : LEN_W'(DR_MAX);
  assign len_eff = (len == '0) ? LEN_W'(1) : ((len > lim) ? lim : len);
  assign step_nx = step_q + STEP_W'(1);

  jscan_halfper #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .load(accept), .run(busy_q),
    .div_i(half_div), .tick(tick)
  );

  jscan_stepgen #(.DR_MAX(DR_MAX), .LEN_W(LEN_W), .STEP_W(STEP_W), .IDX_W(IDX_W)) u_cur (
    .cmd(cmd_q), .n(len_q), .step(step_q),
    .tms(c_tms), .is_data(c_data), .is_last(c_last), .capture(c_cap),
    .data_idx(c_didx), .cap_idx(c_cidx)
  );

  jscan_stepgen #(.DR_MAX(DR_MAX), .LEN_W(LEN_W), .STEP_W(STEP_W), .IDX_W(IDX_W)) u_nxt (
    .cmd(cmd_q), .n(len_q), .step(step_nx),
    .tms(n_tms), .is_data(n_data), .is_last(n_last), .capture(n_cap),
    .data_idx(n_didx), .cap_idx(n_cidx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_RESET;
      len_q   <= LEN_W'(1);
      din_q   <= '0;
      cap_q   <= '0;
      step_q  <= '0;
      phase_q <= PH_SETUP;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      tck_q   <= 1'b0;
      tms_q   <= 1'b1;
      tdi_q   <= 1'b1;
      trst_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trst_q <= trst_req;
      if (accept) begin
        cmd_q   <= cmd_in;
        len_q   <= len_eff;
        din_q   <= din;
        cap_q   <= '0;
        step_q  <= '0;
        phase_q <= PH_SETUP;
        busy_q  <= 1'b1;
        tck_q   <= 1'b0;
        tms_q   <= 1'b1;
        tdi_q   <= 1'b1;
      end else if (busy_q && tick) begin
        case (phase_q)
          PH_SETUP: begin
            tck_q   <= 1'b1;
            phase_q <= PH_HIGH;
          end
          PH_HIGH: begin
            tck_q   <= 1'b0;
            phase_q <= PH_LOW;
          end
          default: begin
            if (c_cap) cap_q[c_cidx] <= tdo;
            if (c_last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              step_q  <= step_nx;
              phase_q <= PH_SETUP;
              tms_q   <= n_tms;
              tdi_q   <= n_data ? din_q[n_didx] : 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign dout    = cap_q;
  assign tck     = tck_q;
  assign tms     = tms_q;
  assign tdi     = tdi_q;
  assign trst_oe = trst_q;

  // R1: the test clock rests low whenever no command runs
  a_r1_tck_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !tck_q);
  // R2: TMS and TDI hold while TCK is high
  a_r2_pins_steady: assert property (@(posedge clk) disable iff (rst)
    (tck_q && $past(tck_q)) |-> ($stable(tms_q) && $stable(tdi_q)));
  // R8: completion is a single-cycle pulse that ends a busy period
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (!busy_q && $past(busy_q)));
  // R9: a request during a command leaves the latched command alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> ($stable(cmd_q) && $stable(din_q) && $stable(len_q)));
  // R2: the phase register stays within its three legal values
  a_r2_phase_legal: assert property (@(posedge clk) disable iff (rst)
    phase_q != tck_phase_e'(2'd3));
endmodule

// File: tb/jtag_scan_engine_test.sv
module jtag_scan_engine_test;
  localparam int IR_MAX = 8;
  localparam int DR_MAX = 16;
  localparam int LEN_W  = 5;
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHDR = 4, E1DR = 5, PDR = 6, E2DR = 7,
                 UDR = 8, SIR = 9, CIR = 10, SHIR = 11, E1IR = 12, PIR = 13, E2IR = 14, UIR = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [LEN_W-1:0] len = '0;
  logic [15:0] din = '0;
  logic [7:0] half_div = 8'd1;
  logic trst_req = 1'b0;
  logic busy, done, tck, tms, tdi, trst_oe;
  logic [15:0] dout;
  logic tdo = 1'b1;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  jtag_scan_engine #(.IR_MAX(IR_MAX), .DR_MAX(DR_MAX), .DIV_W(8)) uut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .len(len), .din(din),
    .half_div(half_div), .trst_req(trst_req), .busy(busy), .done(done),
    .dout(dout), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .trst_oe(trst_oe)
  );

  // behavioural single-device TAP
  int tap_st = TLR;
  int n_m = 1;
  int pulses = 0;
  logic [31:0] tms_log = '0;
  logic [15:0] sr = '0, cap_pat = '0, rx = '0;
  bit upd_ir = 0, upd_dr = 0;

  function automatic int tap_next(int s, logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    logic [15:0] msk;
    msk = 16'((17'd1 << n_m) - 17'd1);
    if (pulses < 32) tms_log[pulses] = tms;
    pulses = pulses + 1;
    case (tap_st)
      CIR, CDR:   sr = cap_pat & msk;
      SHIR, SHDR: sr = ((sr >> 1) | (16'(tdi) << (n_m - 1))) & msk;
      UIR: begin rx = sr; upd_ir = 1; end
      UDR: begin rx = sr; upd_dr = 1; end
      default: ;
    endcase
    tap_st = tap_next(tap_st, tms);
  end

  always @(negedge tck) tdo = sr[0];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tms(int c, int n, int i);
    int pre;
    if (c == 0) return (i < 7);
    pre = (c == 1) ? 4 : 3;
    if (i < pre) return (c == 1) ? (i < 2) : (i == 0);
    if (i < pre + n) return (i == pre + n - 1);
    return (i == pre + n);
  endfunction

  task automatic run_cmd(input logic [1:0] c, input int l, input logic [15:0] d,
                         input int dv, input logic [15:0] pat, input bit poke);
    int ce, n, lim, steps, dve, bc, guard;
    logic [16:0] msk;
    logic [31:0] expv;
    logic [15:0] held;
    string rq;
    ce  = (c == 2'd3) ? 0 : int'(c);
    lim = (ce == 1) ? IR_MAX : DR_MAX;
    n   = (ce == 0) ? 0 : ((l == 0) ? 1 : ((l > lim) ? lim : l));
    steps = (ce == 0) ? 8 : ((ce == 1) ? n + 6 : n + 5);
    dve = (dv == 0) ? 1 : dv;
    msk = (17'd1 << n) - 17'd1;
    n_m = (n == 0) ? 1 : n;
    cap_pat = pat; pulses = 0; tms_log = '0; upd_ir = 0; upd_dr = 0; rx = '0;
    rq = (ce == 0) ? "R3" : ((ce == 1) ? "R4" : "R5");
    @(negedge clk);
    start = 1'b1; cmd = c; len = LEN_W'(l); din = d; half_div = 8'(dv);
    @(negedge clk);
    start = 1'b0; cmd = 2'd1; len = 5'd2; din = 16'h0;
    bc = 0; guard = 0;
    while (!done && guard < 5000) begin
      if (busy) bc++;
      if (poke && bc == 5) begin start = 1'b1; cmd = 2'd2; len = 5'd3; din = 16'hFFFF; end
      else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check("R8 done seen", 32'(done), 32'd1);
    check("R2 busy cycles", 32'(bc), 32'(3 * steps * dve));
    expv = '0;
    for (int i = 0; i < steps; i++) expv[i] = exp_tms(ce, n, i);
    check({rq, " pulse count"}, 32'(pulses), 32'(steps));
    check({rq, " tms pattern"}, tms_log, expv);
    check({rq, " ends in idle"}, 32'(tap_st), 32'(RTI));
    if (poke) check("R9 result unaffected", 32'(pulses), 32'(steps));
    if (ce == 0) begin
      check("R7 dout after reset cmd", 32'(dout), 32'd0);
    end else begin
      check({rq, " update reached"}, 32'(ce == 1 ? upd_ir : upd_dr), 32'd1);
      check("R6 shifted in", 32'(rx), 32'(d & msk[15:0]));
      check("R7 captured", 32'(dout), 32'(pat & msk[15:0]));
    end
    held = dout;
    @(negedge clk);
    check("R8 done single", 32'(done), 32'd0);
    check("R7 dout held", 32'(dout), 32'(held));
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tck", 32'(tck), 32'd0);
    check("R1 tms", 32'(tms), 32'd1);
    check("R1 tdi", 32'(tdi), 32'd1);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 trst_oe", 32'(trst_oe), 32'd0);
    check("R1 dout", 32'(dout), 32'd0);

    // R10: reset request passes through, idle and mid-command
    trst_req = 1'b1;
    @(negedge clk);
    check("R10 trst asserted", 32'(trst_oe), 32'd1);
    trst_req = 1'b0;
    @(negedge clk);
    check("R10 trst released", 32'(trst_oe), 32'd0);

    for (int dv = 0; dv < 3; dv++) begin
      run_cmd(2'd0, 0, 16'h0, dv, 16'h0, 0);
      for (int l = 0; l <= IR_MAX + 1; l++)
        run_cmd(2'd1, l, 16'hA5C3 ^ 16'(l * 16'h1111), dv, 16'h3C96 + 16'(l * 7), 0);
      for (int l = 0; l <= DR_MAX + 1; l++)
        run_cmd(2'd2, l, 16'h5A3C ^ 16'(l * 16'h0F0F) ^ 16'(dv), dv, 16'hC3A5 - 16'(l * 13), 0);
    end
    run_cmd(2'd3, 4, 16'h1234, 1, 16'h0, 0);
    run_cmd(2'd2, 10, 16'h02D5, 2, 16'h0339, 1);
    run_cmd(2'd1, 5, 16'h0015, 1, 16'h000A, 1);

    // R10 while busy
    @(negedge clk);
    start = 1'b1; cmd = 2'd2; len = 5'd8; din = 16'h00AA; half_div = 8'd2;
    @(negedge clk);
    start = 1'b0; trst_req = 1'b1;
    @(negedge clk);
    check("R10 trst during command", 32'(trst_oe), 32'd1);
    trst_req = 1'b0;
    @(negedge clk);
    check("R10 trst release during command", 32'(trst_oe), 32'd0);
    while (busy) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule